// File: doc/BRIEF.md
# PCI Configuration Address Generator

This block turns a configuration request, given as a bus number, a device/function byte and a register offset, into two words. The first is the byte offset inside a 16 MB local-bus window reserved for configuration traffic. The second is the map-register word that tells the bridge how to turn accesses through that window into PCI configuration cycles. Bus number zero selects a type 0 cycle on the bridge's own segment, and any other bus selects a type 1 cycle that is forwarded downstream.

For a type 0 cycle the target device is picked by a single select line. For low slot numbers that select bit sits in the window offset. For higher slot numbers it moves into the map word, because the window offset has run out of bits. Both outputs are registered. They appear one clock after a request pulse and hold until the next request, so software or a sequencer can load the window registers at its own pace.

Top module: `cfg_addr_gen`

## Requirements
- R1: A request with bus number 0 gives a type 0 cycle: `kind_o` = 0 and map bit 0 (the low-address pass-through) = 0. Any nonzero bus gives a type 1 cycle: `kind_o` = 1 and map bit 0 = 1.
- R2: In a type 0 cycle the offset carries the function (devfn bits 2:0) in bits 10:8 and the register offset in bits 7:0.
- R3: In a type 0 cycle with slot (devfn bits 7:3) from 0 to 12, offset bit slot+11 is set, no other offset bit from 23 to 11 is set, and map bits 15:4 are zero.
- R4: In a type 0 cycle with slot from 13 to 20, map bit slot-5 is set, no other map bit from 15 to 4 is set, and offset bits 23:11 are zero.
- R5: In a type 0 cycle with slot from 21 to 31, the select bit would fall outside the 16-bit map word and is dropped: offset bits 23:11 and map bits 15:4 are all zero.
- R6: In a type 1 cycle the offset is bus in bits 23:16, slot in bits 15:11, function in bits 10:8 and register in bits 7:0, and map bits 15:4 are zero.
- R7: Whenever `valid_o` is high, map bits 3:1 hold the configuration code 3'b101.
- R8: `valid_o` is high in exactly the cycle after a cycle with `req_i` high, and low otherwise.
- R9: While `req_i` is low, `addr_o`, `map_o` and `kind_o` keep their values whatever the other inputs do.
- R10: After reset `valid_o`, `addr_o`, `map_o` and `kind_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe; inputs are captured on this cycle |
| bus_i | input | 8 | Target bus number |
| devfn_i | input | 8 | Slot in bits 7:3, function in bits 2:0 |
| reg_i | input | 8 | Configuration register byte offset |
| valid_o | output | 1 | One-cycle pulse marking fresh outputs |
| addr_o | output | 24 | Offset inside the 16 MB configuration window |
| map_o | output | 16 | Map-register word for the configuration window |
| kind_o | output | 1 | 0 for a type 0 cycle, 1 for a type 1 cycle |

## Verification
On every cycle the assertions check the request-to-valid timing, that the outputs hold between requests, that the configuration code is present, that the pass-through bit agrees with the cycle kind, that at most one device select bit is set across offset and map word, and that type 1 map words carry nothing above the code. The exact placement of each field, the point where the select bit moves from offset to map word at slot 12/13, the dropped select for slots above 20, and the bus-zero decision need concrete values, so only the bench's directed scenarios show them.

// File: rtl/cfg_addr_pkg.sv
package cfg_addr_pkg;

    parameter int CFG_BUS_W   = 8;
    parameter int CFG_DEVFN_W = 8;
    parameter int CFG_REG_W   = 8;
    parameter int CFG_FUNC_W  = 3;
    parameter int CFG_ADDR_W  = 24;
    parameter int CFG_MAP_W   = 16;

    // highest slot whose select bit still fits in the window offset
    parameter int CFG_LOW_SLOT_MAX = 12;
    // first offset bit used for a type 0 device select
    parameter int CFG_SEL_BASE     = 11;
    // first map bit used for a type 0 device select
    parameter int CFG_MAP_SEL_BASE = 8;

    localparam logic [2:0] CFG_TYPE_CODE = 3'b101;

    typedef enum logic {
        CYC_TYPE0 = 1'b0,
        CYC_TYPE1 = 1'b1
    } cyc_kind_e;

endpackage

// File: rtl/cfg_type0_sel.sv
module cfg_type0_sel
    import cfg_addr_pkg::*;
#(
    parameter int SLOT_W       = 5,
    parameter int ADDR_W       = CFG_ADDR_W,
    parameter int MAP_W        = CFG_MAP_W,
    parameter int LOW_MAX      = CFG_LOW_SLOT_MAX,
    parameter int SEL_BASE     = CFG_SEL_BASE,
    parameter int MAP_SEL_BASE = CFG_MAP_SEL_BASE
) (
    input  logic [SLOT_W-1:0] slot_i,
    output logic [ADDR_W-1:0] addr_sel_o,
    output logic [MAP_W-1:0]  map_sel_o
);

    localparam int NSLOT    = 1 << SLOT_W;
    localparam int HIGH_MIN = LOW_MAX + 1;

    // one comparator per offset bit: low slots land in the offset
    for (genvar b = 0; b < ADDR_W; b++) begin : g_abit
        if (b >= SEL_BASE && b <= SEL_BASE + LOW_MAX) begin : g_sel
            assign addr_sel_o[b] = (slot_i == SLOT_W'(b - SEL_BASE));
        end else begin : g_zero
            assign addr_sel_o[b] = 1'b0;
        end
    end

    // high slots land in the map word; those past its top are dropped
    for (genvar b = 0; b < MAP_W; b++) begin : g_mbit
        if (b >= MAP_SEL_BASE && (b - MAP_SEL_BASE + HIGH_MIN) < NSLOT) begin : g_sel
            assign map_sel_o[b] = (slot_i == SLOT_W'(b - MAP_SEL_BASE + HIGH_MIN));
        end else begin : g_zero
            assign map_sel_o[b] = 1'b0;
        end
    end

endmodule

// File: rtl/cfg_type1_fmt.sv
module cfg_type1_fmt
    import cfg_addr_pkg::*;
#(
    parameter int BUS_W   = CFG_BUS_W,
    parameter int DEVFN_W = CFG_DEVFN_W,
    parameter int REG_W   = CFG_REG_W,
    parameter int ADDR_W  = CFG_ADDR_W
) (
    input  logic [BUS_W-1:0]   bus_i,
    input  logic [DEVFN_W-1:0] devfn_i,
    input  logic [REG_W-1:0]   reg_i,
    output logic [ADDR_W-1:0]  addr_o
);

    localparam int PACK_W = BUS_W + DEVFN_W + REG_W;
    localparam int PAD_W  = (ADDR_W > PACK_W) ? ADDR_W - PACK_W : 0;

    if (PAD_W > 0) begin : g_pad
        assign addr_o = {{PAD_W{1'b0}}, bus_i, devfn_i, reg_i};
    end else begin : g_fit
        logic [PACK_W-1:0] packed_w;
        assign packed_w = {bus_i, devfn_i, reg_i};
        assign addr_o   = packed_w[ADDR_W-1:0];
    end

endmodule

// File: rtl/cfg_addr_gen.sv
module cfg_addr_gen
    import cfg_addr_pkg::*;
#(
    parameter int BUS_W   = CFG_BUS_W,
    parameter int DEVFN_W = CFG_DEVFN_W,
    parameter int REG_W   = CFG_REG_W,
    parameter int FUNC_W  = CFG_FUNC_W,
    parameter int ADDR_W  = CFG_ADDR_W,
    parameter int MAP_W   = CFG_MAP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic [BUS_W-1:0]   bus_i,
    input  logic [DEVFN_W-1:0] devfn_i,
    input  logic [REG_W-1:0]   reg_i,
    output logic               valid_o,
    output logic [ADDR_W-1:0]  addr_o,
    output logic [MAP_W-1:0]   map_o,
    output logic               kind_o
);

    localparam int SLOT_W   = DEVFN_W - FUNC_W;
    localparam int SEL_LO   = CFG_SEL_BASE;
    localparam int MSEL_LO  = 4;

    typedef struct packed {
        logic              valid;
        cyc_kind_e         kind;
        logic [ADDR_W-1:0] addr;
        logic [MAP_W-1:0]  map;
    } gen_state_t;

    gen_state_t st_d, st_q;

    logic [SLOT_W-1:0] slot_w;
    logic [FUNC_W-1:0] func_w;
    logic [ADDR_W-1:0] t0_sel_w;
    logic [MAP_W-1:0]  t0_map_sel_w;
    logic [ADDR_W-1:0] t1_addr_w;

    assign slot_w = devfn_i[DEVFN_W-1:FUNC_W];
    assign func_w = devfn_i[FUNC_W-1:0];

    cfg_type0_sel #(
        .SLOT_W (SLOT_W),
        .ADDR_W (ADDR_W),
        .MAP_W  (MAP_W)
    ) u_type0 (
        .slot_i     (slot_w),
        .addr_sel_o (t0_sel_w),
        .map_sel_o  (t0_map_sel_w)
    );

    cfg_type1_fmt #(
        .BUS_W   (BUS_W),
        .DEVFN_W (DEVFN_W),
        .REG_W   (REG_W),
        .ADDR_W  (ADDR_W)
    ) u_type1 (
        .bus_i   (bus_i),
        .devfn_i (devfn_i),
        .reg_i   (reg_i),
        .addr_o  (t1_addr_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = req_i;
        if (req_i) begin
            st_d.map      = '0;
            st_d.map[3:1] = CFG_TYPE_CODE;
            if (bus_i != '0) begin
                st_d.kind   = CYC_TYPE1;
                st_d.map[0] = 1'b1;
                st_d.addr   = t1_addr_w;
            end else begin
                st_d.kind   = CYC_TYPE0;
                st_d.map[0] = 1'b0;
                st_d.map    = st_d.map | t0_map_sel_w;
                st_d.addr   = t0_sel_w;
                st_d.addr[REG_W +: FUNC_W] = func_w;
                st_d.addr[REG_W-1:0]       = reg_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign kind_o  = st_q.kind;
    assign addr_o  = st_q.addr;
    assign map_o   = st_q.map;

    // R8
    req_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> valid_o);

    // R8
    idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !valid_o);

    // R9
    hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> ($stable(addr_o) && $stable(map_o) && $stable(kind_o)));

    // R7
    type_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (map_o[3:1] == 3'b101));

    // R1
    passthru_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (map_o[0] == kind_o));

    // R3 R4 R5
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !kind_o) |-> $onehot0({addr_o[ADDR_W-1:SEL_LO], map_o[MAP_W-1:MSEL_LO]}));

    // R6
    t1_map_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && kind_o) |-> (map_o[MAP_W-1:MSEL_LO] == '0));

endmodule

// File: tb/cfg_addr_gen_bench.sv
`timescale 1ns/1ps
module cfg_addr_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [7:0]  bus_i = '0;
    logic [7:0]  devfn_i = '0;
    logic [7:0]  reg_i = '0;
    logic        valid_o;
    logic [23:0] addr_o;
    logic [15:0] map_o;
    logic        kind_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cfg_addr_gen u_cfg_addr_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .bus_i   (bus_i),
        .devfn_i (devfn_i),
        .reg_i   (reg_i),
        .valid_o (valid_o),
        .addr_o  (addr_o),
        .map_o   (map_o),
        .kind_o  (kind_o)
    );

    function automatic logic [23:0] want_addr(logic [7:0] b, logic [7:0] df, logic [7:0] r);
        logic [23:0] a;
        int s;
        if (b != 0) return {b, df, r};
        a = {13'd0, df[2:0], r};
        s = int'(df[7:3]);
        if (s <= 12) a[s + 11] = 1'b1;
        return a;
    endfunction

    function automatic logic [15:0] want_map(logic [7:0] b, logic [7:0] df);
        logic [15:0] m;
        int s;
        m = 16'h000A;
        if (b != 0) return m | 16'h0001;
        s = int'(df[7:3]);
        if (s >= 13 && s <= 20) m[s - 5] = 1'b1;
        return m;
    endfunction

    task automatic check(string tag, logic [23:0] ea, logic [15:0] em, logic ek, logic ev);
        checks++;
        if (addr_o !== ea || map_o !== em || kind_o !== ek || valid_o !== ev) begin
            errors++;
            $display("FAIL %s: got addr=%h map=%h kind=%b valid=%b expected addr=%h map=%h kind=%b valid=%b",
                     tag, addr_o, map_o, kind_o, valid_o, ea, em, ek, ev);
        end
    endtask

    task automatic issue(logic [7:0] b, logic [7:0] df, logic [7:0] r);
        @(negedge clk);
        req_i = 1'b1; bus_i = b; devfn_i = df; reg_i = r;
        @(negedge clk);
        req_i = 1'b0;
    endtask

    task automatic run_one(string tag, logic [7:0] b, logic [7:0] df, logic [7:0] r);
        issue(b, df, r);
        check(tag, want_addr(b, df, r), want_map(b, df), (b != 0), 1'b1);
    endtask

    // R10
    task automatic t_reset();
        check("R10 reset", 24'h0, 16'h0, 1'b0, 1'b0);
    endtask

    // R1 R2 R3: low slots select through the offset
    task automatic t_type0_low();
        run_one("R3 slot0 fn0", 8'd0, {5'd0, 3'd0}, 8'h00);
        run_one("R2 R3 slot5 fn6", 8'd0, {5'd5, 3'd6}, 8'h3C);
        run_one("R3 slot12 edge", 8'd0, {5'd12, 3'd7}, 8'hFF);
    endtask

    // R4: high slots select through the map word
    task automatic t_type0_high();
        run_one("R4 slot13 edge", 8'd0, {5'd13, 3'd1}, 8'h04);
        run_one("R4 slot20", 8'd0, {5'd20, 3'd2}, 8'h10);
    endtask

    // R5: select past the map word is dropped
    task automatic t_type0_drop();
        run_one("R5 slot21", 8'd0, {5'd21, 3'd0}, 8'h08);
        run_one("R5 slot31", 8'd0, {5'd31, 3'd7}, 8'hFC);
    endtask

    // R1 R6 R7: type 1 field packing
    task automatic t_type1();
        run_one("R6 bus1", 8'd1, {5'd3, 3'd2}, 8'h40);
        run_one("R6 busFF slot31", 8'hFF, {5'd31, 3'd7}, 8'hFF);
        run_one("R1 R7 bus80 slot20", 8'h80, {5'd20, 3'd0}, 8'h00);
    endtask

    // R8 R9: single pulse, hold while idle
    task automatic t_hold();
        logic [23:0] ea;
        logic [15:0] em;
        ea = want_addr(8'd0, {5'd7, 3'd3}, 8'h24);
        em = want_map(8'd0, {5'd7, 3'd3});
        issue(8'd0, {5'd7, 3'd3}, 8'h24);
        check("R8 pulse high", ea, em, 1'b0, 1'b1);
        bus_i = 8'h55; devfn_i = 8'hAA; reg_i = 8'h11;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R9 R8 hold idle", ea, em, 1'b0, 1'b0);
        end
    endtask

    // R8: back-to-back requests each produce their own result
    task automatic t_back_to_back();
        @(negedge clk);
        req_i = 1'b1; bus_i = 8'd2; devfn_i = 8'h19; reg_i = 8'h0C;
        @(negedge clk);
        check("R8 b2b first", want_addr(8'd2, 8'h19, 8'h0C), want_map(8'd2, 8'h19), 1'b1, 1'b1);
        bus_i = 8'd0; devfn_i = {5'd14, 3'd4}; reg_i = 8'h30;
        @(negedge clk);
        req_i = 1'b0;
        check("R8 R1 b2b second", want_addr(8'd0, {5'd14, 3'd4}, 8'h30),
              want_map(8'd0, {5'd14, 3'd4}), 1'b0, 1'b1);
    endtask

    initial begin
        #40000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_type0_low();
        t_type0_high();
        t_type0_drop();
        t_type1();
        t_hold();
        t_back_to_back();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule